// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Hand-Off

The engine copies a block of data units from a source address to a destination address on a shared memory bus, so that a processor does not have to move each unit itself. Software programs a source address, a destination address, a unit count and a control word through a small register port. Setting the run bit starts the channel. The engine then asks for the bus with a request line and waits for the grant. For each unit it runs one read followed by one write, and it stretches either phase for as long as the bus holds its ready input low.

Three directions are supported: peripheral to memory, memory to peripheral, and memory to memory. In the first two, each bus ownership waits for the peripheral's request line. The peripheral side and the memory side each have their own data size. Each side's address advances by that size. A channel either keeps the bus for the whole block (burst) or gives it back after every unit (cycle stealing). In circular operation the programmed values reload at the end of each block, and the channel keeps running. A half-way flag and a completion flag can each drive the interrupt output. An illegal start request is refused and recorded in an error flag.

Top module: `xfer_engine`

## Requirements
- R1: After reset the engine is idle: `breq`, `bus_rd`, `bus_wr` and `irq` are 0, and the control (offset 3) and status (offset 4) registers read 0.
- R2: Writing offset 0 (source), 1 (destination) or 2 (count) loads both the stored base value and the working value. Reading these offsets returns the working value, which is the current address or the remaining count.
- R3: While the engine is not idle, writes to offsets 0 to 3 are ignored. The status register stays writable.
- R4: `breq` is 0 whenever the engine is idle. `bus_rd` and `bus_wr` are never 1 together, and they are driven only while `bgnt` is 1. After giving up the bus, the engine waits for `bgnt` to go low before it requests again.
- R5: Each unit is a read at the current source address, then a write at the current destination address. Each phase stays on the bus until a cycle in which `bus_ready` is 1.
- R6: Size codes: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit. Each address advances by its own side's size after every unit. Read data is cut to the source size, and the written data is cut to the destination size (zero-extended). `bus_size` shows the size of the current phase.
- R7: Control bits [2:1] select the direction. 00 is peripheral to memory: the source uses the peripheral size in bits [6:5]. 01 is memory to peripheral: the destination uses the peripheral size. 10 is memory to memory: both sides use the memory size in bits [8:7], and `dreq` is not needed. For directions 00 and 01, the bus is requested only while `dreq` is 1.
- R8: With control bit 3 set (cycle stealing), `breq` drops in the cycle after every completed write, and the next unit requests the bus again.
- R9: With control bit 3 clear (burst), `breq` stays high from the first grant to the last write of the block.
- R10: Status bit 0 (half) is set by the write after which the remaining count equals the programmed count divided by two, rounded down.
- R11: Status bit 1 (done) is set by the last write of a block. Without circular mode, this clears the run bit (control bit 0). `irq` is the OR of half AND control bit 9 with done AND control bit 10.
- R12: With control bit 4 (circular) set, the last write of a block reloads the working addresses and count from the base values, and the channel keeps running with the run bit still set.
- R13: A start is refused when the count is 0, the direction is 11, either size is 11, or memory-to-memory is combined with circular. A refused start sets status bit 2 (error), leaves the run bit at 0 and never requests the bus.
- R14: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| dreq | input | 1 | Peripheral service request |
| breq | output | 1 | Bus request |
| bgnt | input | 1 | Bus grant |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read phase active |
| bus_wr | output | 1 | Write phase active |
| bus_size | output | 2 | Size code of the current phase |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Phase completes in this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the bus owner keeps `bgnt` high for as long as `breq` is high, and lowers it some time after `breq` falls. They also assume that `bus_ready` only matters while a phase is active. The bench's bus model gives the grant one cycle after the request and takes it away one cycle after the release. It inserts a programmable number of wait states and returns read data computed from the address. It holds `dreq` steady while a peripheral-paced transfer is meant to proceed.

// File: rtl/xfer_pkg.sv
// Shared types and helpers for the block transfer engine.
// Assumes a 32-bit bus data path; size codes above 2 are reserved.
package xfer_pkg;
    localparam int DW = 32;

    typedef enum logic [1:0] {DIR_P2M = 2'd0, DIR_M2P = 2'd1, DIR_M2M = 2'd2, DIR_BAD = 2'd3} dir_e;

    // Control word, bit 0 first: run, dir[2:1], steal[3], circ[4], psize[6:5], msize[8:7], half_ie[9], done_ie[10]
    typedef struct packed {
        logic       done_ie;
        logic       half_ie;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       circ;
        logic       steal;
        dir_e       dir;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_REQ, ST_RD, ST_WR, ST_REL} st_e;

    // Cut a data word down to the width named by a size code, zero-extended.
    function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic [1:0] sz);
        case (sz)
            2'd0:    fit = {24'd0, d[7:0]};
            2'd1:    fit = {16'd0, d[15:0]};
            default: fit = d;
        endcase
    endfunction

    // True when a control word may legally start a transfer.
    function automatic logic start_ok(input ctrl_t c, input logic cnt_nz);
        start_ok = cnt_nz && (c.dir != DIR_BAD) && (c.psize != 2'd3) && (c.msize != 2'd3)
                   && !((c.dir == DIR_M2M) && c.circ);
    endfunction
endpackage

// File: rtl/xfer_regs.sv
// Register port of the transfer engine: base values, control word, status flags, interrupt.
// Assumes the control part reports busy, the working values and single-cycle events.
module xfer_regs
    import xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          busy,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  logic [CW-1:0] cur_cnt,
    input  logic          evt_half,
    input  logic          evt_done,
    output logic [AW-1:0] base_src,
    output logic [AW-1:0] base_dst,
    output logic [CW-1:0] base_cnt,
    output ctrl_t         ctrl,
    output logic          ld_src,
    output logic          ld_dst,
    output logic          ld_cnt,
    output logic [2:0]    flags,
    output logic          irq
);
    logic  idle_wr;
    ctrl_t new_ctrl;
    logic  new_ok;
    logic  [2:0] set_f;
    logic  [2:0] clr_f;

    // Decode writes, which are legal only while idle (status excepted).
    always_comb begin
        idle_wr  = cfg_we && !busy;
        ld_src   = idle_wr && (cfg_addr == 3'd0);
        ld_dst   = idle_wr && (cfg_addr == 3'd1);
        ld_cnt   = idle_wr && (cfg_addr == 3'd2);
        new_ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        new_ok   = start_ok(new_ctrl, base_cnt != '0);
    end

    // Base value storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_src <= '0;
            base_dst <= '0;
            base_cnt <= '0;
        end else begin
            if (ld_src) base_src <= AW'(cfg_wdata);
            if (ld_dst) base_dst <= AW'(cfg_wdata);
            if (ld_cnt) base_cnt <= CW'(cfg_wdata);
        end
    end

    // Control word: accept while idle, refuse illegal starts, drop run at the end of a one-shot block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (idle_wr && cfg_addr == 3'd3) begin
            ctrl     <= new_ctrl;
            ctrl.run <= new_ctrl.run && new_ok;
        end else if (evt_done && !ctrl.circ) begin
            ctrl.run <= 1'b0;
        end
    end

    // Status flag sources: events set, written ones clear, a set wins.
    always_comb begin
        set_f    = {idle_wr && cfg_addr == 3'd3 && new_ctrl.run && !new_ok, evt_done, evt_half};
        clr_f    = (cfg_we && cfg_addr == 3'd4) ? cfg_wdata[2:0] : 3'b000;
    end

    // Status flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_f) | set_f;
    end

    // Interrupt and read-back mux.
    always_comb begin
        irq = (flags[0] && ctrl.half_ie) || (flags[1] && ctrl.done_ie);
        case (cfg_addr)
            3'd0:    cfg_rdata = RW'(cur_src);
            3'd1:    cfg_rdata = RW'(cur_dst);
            3'd2:    cfg_rdata = RW'(cur_cnt);
            3'd3:    cfg_rdata = RW'(ctrl);
            3'd4:    cfg_rdata = RW'(flags);
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_ctl.sv
// Sequencer and working registers of the transfer engine: bus hand-off, read/write phases,
// address stepping, count, circular reload. Assumes bgnt stays high while breq is high.
module xfer_ctl
    import xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] base_src,
    input  logic [AW-1:0] base_dst,
    input  logic [CW-1:0] base_cnt,
    input  logic          ld_src,
    input  logic          ld_dst,
    input  logic          ld_cnt,
    input  logic [RW-1:0] ld_data,
    input  logic          dreq,
    input  logic          bgnt,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    output logic          breq,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    output logic          evt_half,
    output logic          evt_done
);
    st_e           st, st_nx;
    logic [1:0]    src_sz, dst_sz;
    logic [DW-1:0] hold_q;
    logic          wr_fin, last, reload;

    // Side sizes, completion and event decode.
    always_comb begin
        src_sz   = (ctrl.dir == DIR_P2M) ? ctrl.psize : ctrl.msize;
        dst_sz   = (ctrl.dir == DIR_M2P) ? ctrl.psize : ctrl.msize;
        bus_rd   = (st == ST_RD) && bgnt;
        bus_wr   = (st == ST_WR) && bgnt;
        breq     = (st == ST_REQ) || (st == ST_RD) || (st == ST_WR);
        busy     = (st != ST_IDLE);
        wr_fin   = bus_wr && bus_ready;
        last     = (cur_cnt == CW'(1));
        reload   = wr_fin && last && ctrl.circ;
        evt_done = wr_fin && last;
        evt_half = wr_fin && ((cur_cnt - CW'(1)) == (base_cnt >> 1));
        bus_addr = (st == ST_WR) ? cur_dst : cur_src;
        bus_size = (st == ST_WR) ? dst_sz : src_sz;
        bus_wdata = fit(hold_q, dst_sz);
    end

    // Next-state logic of the bus sequencer.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (ctrl.run) st_nx = ST_WAIT;
            ST_WAIT: if (ctrl.dir == DIR_M2M || dreq) st_nx = ST_REQ;
            ST_REQ:  if (bgnt) st_nx = ST_RD;
            ST_RD:   if (bus_rd && bus_ready) st_nx = ST_WR;
            ST_WR:   if (wr_fin) st_nx = (last || ctrl.steal) ? ST_REL : ST_RD;
            ST_REL:  if (!bgnt) st_nx = ctrl.run ? ST_WAIT : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Read data holding register, cut to the source size.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hold_q <= '0;
        else if (bus_rd && bus_ready) hold_q <= fit(bus_rdata, src_sz);
    end

    // Working address and count registers: load, step or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src <= '0;
            cur_dst <= '0;
            cur_cnt <= '0;
        end else if (reload) begin
            cur_src <= base_src;
            cur_dst <= base_dst;
            cur_cnt <= base_cnt;
        end else if (wr_fin) begin
            cur_src <= cur_src + (AW'(1) << src_sz);
            cur_dst <= cur_dst + (AW'(1) << dst_sz);
            cur_cnt <= cur_cnt - CW'(1);
        end else begin
            if (ld_src) cur_src <= AW'(ld_data);
            if (ld_dst) cur_dst <= AW'(ld_data);
            if (ld_cnt) cur_cnt <= CW'(ld_data);
        end
    end
endmodule

// File: rtl/xfer_engine.sv
// Top of the single-channel block transfer engine: register port plus bus sequencer.
// Assumes RW is at least as wide as the control word and as AW and CW.
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    localparam int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          dreq,
    output logic          breq,
    input  logic          bgnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          irq
);
    ctrl_t         ctrl_w;
    logic [AW-1:0] base_src_w, base_dst_w, cur_src_w, cur_dst_w;
    logic [CW-1:0] base_cnt_w, cur_cnt_w;
    logic          ld_src_w, ld_dst_w, ld_cnt_w, busy_w, evt_half_w, evt_done_w;
    logic [2:0]    flags_w;

    xfer_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy_w),
        .cur_src(cur_src_w), .cur_dst(cur_dst_w), .cur_cnt(cur_cnt_w),
        .evt_half(evt_half_w), .evt_done(evt_done_w),
        .base_src(base_src_w), .base_dst(base_dst_w), .base_cnt(base_cnt_w),
        .ctrl(ctrl_w), .ld_src(ld_src_w), .ld_dst(ld_dst_w), .ld_cnt(ld_cnt_w),
        .flags(flags_w), .irq(irq)
    );

    xfer_ctl #(.AW(AW), .CW(CW), .RW(RW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_w),
        .base_src(base_src_w), .base_dst(base_dst_w), .base_cnt(base_cnt_w),
        .ld_src(ld_src_w), .ld_dst(ld_dst_w), .ld_cnt(ld_cnt_w), .ld_data(cfg_wdata),
        .dreq(dreq), .bgnt(bgnt), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .busy(busy_w), .cur_src(cur_src_w), .cur_dst(cur_dst_w), .cur_cnt(cur_cnt_w),
        .breq(breq), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .evt_half(evt_half_w), .evt_done(evt_done_w)
    );
endmodule

// File: rtl/xfer_engine_chk.sv
// Property checker for the transfer engine, bound to its top.
// Assumes bgnt stays high while breq is high.
module xfer_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          breq,
    input logic          bgnt,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_ready,
    input logic          busy,
    input logic          steal,
    input logic [CW-1:0] cur_cnt,
    input logic [AW-1:0] base_src,
    input logic          done_f,
    input logic          err_f
);
    // R4
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !breq);
    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({bus_rd, bus_wr}));
    // R4
    drive_granted_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd || bus_wr) |-> bgnt);
    // R8
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steal && bus_wr && bus_ready) |=> !breq);
    // R9
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!steal && bus_wr && bus_ready && cur_cnt != CW'(1)) |=> breq);
    // R3
    base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(base_src));
    // R11
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_f) |-> $past(bus_wr && bus_ready));
    // R13
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_f) |-> (!busy && !breq));
endmodule

bind xfer_engine xfer_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .breq(breq), .bgnt(bgnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ready(bus_ready), .busy(busy_w), .steal(ctrl_w.steal), .cur_cnt(cur_cnt_w),
    .base_src(base_src_w), .done_f(flags_w[1]), .err_f(flags_w[2])
);

// File: tb/xfer_engine_test.sv
// Scoreboard bench: a driver task queues expected writes, a monitor pops and compares them.
module xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        dreq = 1'b0;
    logic        breq, bgnt, bus_rd, bus_wr, bus_ready, irq;
    logic [15:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;

    int checks = 0, fails = 0, ws_set = 0, ws_cnt = 0, rises = 0, wr_seen = 0;
    bit mon_on = 1'b0, prev_breq = 1'b0, ended = 1'b0;
    logic [49:0] exp_q[$];

    always #10 clk = ~clk;

    xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dreq(dreq), .breq(breq), .bgnt(bgnt), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
    );

    function automatic logic [31:0] word_at(input logic [15:0] a);
        return {a ^ 16'h5A5A, ~a};
    endfunction

    function automatic logic [31:0] cut(input logic [31:0] d, input int sz);
        if (sz == 0) return d & 32'hFF;
        if (sz == 1) return d & 32'hFFFF;
        return d;
    endfunction

    assign bus_rdata = word_at(bus_addr);
    assign bus_ready = (bus_rd || bus_wr) && (ws_cnt >= ws_set);

    // Bus owner and wait-state model.
    always @(posedge clk) begin
        if (!rst_n) begin
            bgnt   <= 1'b0;
            ws_cnt <= 0;
        end else begin
            bgnt   <= breq;
            ws_cnt <= ((bus_rd || bus_wr) && !bus_ready) ? ws_cnt + 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [49:0] act, input logic [49:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each accepted write with the queue head; count request rises.
    always @(negedge clk) begin
        if (rst_n && breq && !prev_breq) rises++;
        prev_breq = breq;
        if (rst_n && mon_on && bus_wr && bus_ready) begin
            wr_seen++;
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", {bus_addr, bus_wdata, bus_size}, '0);
            else begin
                logic [49:0] e;
                e = exp_q.pop_front();
                // R5 R6 R7 address, data and size of the write phase
                chk({bus_addr, bus_wdata, bus_size} == e, "R6 write beat", {bus_addr, bus_wdata, bus_size}, e);
            end
        end
    end

    // Driver: queue n expected writes, wrapping every per units.
    task automatic push_beats(input logic [15:0] sa, input logic [15:0] da, input int ssz, input int dsz,
                              input int n, input int per);
        for (int i = 0; i < n; i++) begin
            logic [15:0] s, d;
            s = sa + 16'((i % per) << ssz);
            d = da + 16'((i % per) << dsz);
            exp_q.push_back({d, cut(cut(word_at(s), ssz), dsz), 2'(dsz)});
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_done();
        logic [15:0] d;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd4, d);
            if (d[1]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        do_reset();
        // R1 reset state
        chk(!breq && !bus_rd && !bus_wr && !irq, "R1 outputs", {breq, bus_rd, bus_wr, irq}, 0);
        rd(3'd3, d); chk(d == 0, "R1 control", d, 0);
        rd(3'd4, d); chk(d == 0, "R1 status", d, 0);

        // Memory to memory, burst, 16-bit, 4 units, irq enables on
        mon_on = 1'b1; wr_seen = 0; rises = 0;
        wr(0, 16'h0100); wr(1, 16'h0200); wr(2, 16'd4);
        rd(3'd2, d); chk(d == 4, "R2 count readback", d, 4);
        push_beats(16'h0100, 16'h0200, 1, 1, 4, 4);
        wr(3, 16'h0001 | (16'd2 << 1) | (16'd1 << 7) | (16'd1 << 9) | (16'd1 << 10));
        wait_done();
        rd(3'd4, d); chk(d == 3, "R10 R11 half and done", d, 3);
        chk(irq == 1'b1, "R11 irq", irq, 1);
        rd(3'd0, d); chk(d == 16'h0108, "R2 R6 source advanced", d, 16'h0108);
        rd(3'd2, d); chk(d == 0, "R2 count exhausted", d, 0);
        rd(3'd3, d); chk(d[0] == 1'b0, "R11 run cleared", d[0], 0);
        chk(rises == 1, "R9 single bus tenure", rises, 1);
        chk(exp_q.size() == 0, "R5 all beats seen", exp_q.size(), 0);

        // R14 write-one-to-clear
        wr(4, 16'h0001); rd(3'd4, d); chk(d == 2, "R14 clear half only", d, 2);
        chk(irq == 1'b1, "R14 done still raises irq", irq, 1);
        wr(4, 16'h0002); rd(3'd4, d); chk(d == 0, "R14 clear done", d, 0);
        chk(irq == 1'b0, "R14 irq low", irq, 0);

        // Peripheral to memory, cycle stealing, 8-bit to 32-bit, wait states
        ws_set = 2; wr_seen = 0; rises = 0; dreq = 1'b0;
        wr(0, 16'h0010); wr(1, 16'h0400); wr(2, 16'd3);
        push_beats(16'h0010, 16'h0400, 0, 2, 3, 3);
        wr(3, 16'h0001 | (16'd1 << 3) | (16'd0 << 5) | (16'd2 << 7));
        repeat (20) @(negedge clk);
        chk(breq == 1'b0 && rises == 0, "R7 waits for dreq", rises, 0);
        dreq = 1'b1;
        wr(0, 16'h7777);
        wait (wr_seen == 1); @(posedge clk);
        rd(3'd4, d); chk(d[0] == 1'b0, "R10 half not yet", d, 0);
        wait (wr_seen == 2); @(posedge clk);
        rd(3'd4, d); chk(d[0] == 1'b1, "R10 half at midpoint", d, 1);
        wait_done();
        chk(rises == 3, "R8 request per unit", rises, 3);
        rd(3'd0, d); chk(d == 16'h0013, "R3 busy write ignored", d, 16'h0013);
        chk(irq == 1'b0, "R11 irq gated by enables", irq, 0);
        chk(exp_q.size() == 0, "R5 all beats seen", exp_q.size(), 0);
        dreq = 1'b0;
        wr(4, 16'h0007);

        // R13 refused starts
        rises = 0;
        wr(2, 16'd2); wr(3, 16'h0001 | (16'd2 << 1) | (16'd1 << 4));
        repeat (5) @(negedge clk);
        rd(3'd4, d); chk(d == 4, "R13 memory+circular error", d, 4);
        rd(3'd3, d); chk(d[0] == 1'b0, "R13 run stays 0", d[0], 0);
        chk(rises == 0, "R13 no request", rises, 0);
        wr(4, 16'h0004); wr(2, 16'd0); wr(3, 16'h0001 | (16'd2 << 1));
        rd(3'd4, d); chk(d == 4, "R13 zero count error", d, 4);
        wr(4, 16'h0004); wr(2, 16'd2); wr(3, 16'h0001 | (16'd3 << 5));
        rd(3'd4, d); chk(d == 4, "R13 reserved size error", d, 4);
        chk(rises == 0, "R13 still no request", rises, 0);
        wr(4, 16'h0004);

        // Circular memory to peripheral, burst, 8-bit to 32-bit
        ws_set = 1; wr_seen = 0; dreq = 1'b1;
        wr(0, 16'h0300); wr(1, 16'h0040); wr(2, 16'd2);
        push_beats(16'h0300, 16'h0040, 0, 2, 5, 2);
        wr(3, 16'h0001 | (16'd1 << 1) | (16'd1 << 4) | (16'd2 << 5) | (16'd0 << 7) | (16'd1 << 10));
        wait (wr_seen == 5);
        @(negedge clk);
        chk(exp_q.size() == 0, "R12 reload addresses", exp_q.size(), 0);
        rd(3'd3, d); chk(d[0] == 1'b1, "R12 run kept", d[0], 1);
        rd(3'd4, d); chk(d[1] == 1'b1, "R12 done each pass", d, 2);
        chk(irq == 1'b1, "R12 irq from done", irq, 1);
        mon_on = 1'b0; dreq = 1'b0;
        do_reset();

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule